// File: doc/BRIEF.md
# ECC Syndrome Fault Locator

This block turns a corrected-error report into a physical fault location. Each request carries the ECC syndrome code, the low address bits that locate the failing quadword inside a 64-byte line, and bank decode information taken from elsewhere. From these the block finds the failing memory module and the failing pin.

Internally the syndrome is first reordered into the bit's position on a 144-bit beat. That position is then placed inside the 576-bit, four-beat line transfer. The result indexes two lookup tables: a packed module map of 2-bit fields and a pin map.

Two table sets are kept, one for symmetric population and one for asymmetric population. Software fills both sets through a write port. A per-request flag chooses the set. Results return a fixed two cycles after the request because both tables are synchronous-read memories.

Top module: `ecc_fault_locator`

## Requirements
- R1: A request sampled with `req_valid` high produces exactly one cycle of `rsp_valid` two cycles later. Requests on consecutive cycles each produce a response, in order.
- R2: `rsp_unknown` is 1, with `rsp_multi`, `rsp_module` and `rsp_pin` all 0, in two cases: when `req_bank_hit` is 0, or when the signed syndrome lies outside -1..144.
- R3: Syndrome -1 with a bank hit reports a multi-bit error. In that case `rsp_multi` is 1, `rsp_module` is 4 × `req_bank_group`, and `rsp_pin` is 0.
- R4: A valid single-bit syndrome c is turned into a bus position b using these rules:
  - c below 128: b = c + 16
  - c from 128 to 143: b = c − 137
  - c = 144: b = 1
- R5: The quadword is q = `req_line_off` / 16. The line position is p = (3 − q) × 144 + b. `rsp_pin` is the pin-map entry at index p. A negative p reports unknown, as in R2.
- R6: The reversed position is r = 575 − p. The selector is bit 6 − 2 × (r mod 4) of module-map byte r / 4. `rsp_module` is 4 × `req_bank_group` + selector.
- R7: With `req_symmetric` = 1 the lookup uses table set 0, otherwise set 1. A write goes to the set given by `map_wr_set`. It goes to the pin map when `map_wr_pin` = 1, and to the module map (low 8 data bits) when it is 0. Each entry is addressed by `map_wr_addr`.
- R8: A lookup in the same cycle as a write to the entry it reads returns the entry's previous contents. The next lookup returns the new contents.
- R9: After reset, and in every cycle where `rsp_valid` is 0, all response outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| map_wr_en | input | 1 | Table write strobe |
| map_wr_pin | input | 1 | 1 selects the pin map, 0 the module map |
| map_wr_set | input | 1 | Table set written |
| map_wr_addr | input | 10 | Entry index |
| map_wr_data | input | 10 | Entry value (module map uses bits 7:0) |
| req_valid | input | 1 | Lookup request |
| req_syndrome | input | 10 | Signed syndrome code |
| req_line_off | input | 6 | Byte offset of the error within the line |
| req_bank_hit | input | 1 | Bank decode matched |
| req_bank_group | input | 1 | Low bit of the matched bank index |
| req_symmetric | input | 1 | Symmetric layout, selects table set 0 |
| rsp_valid | output | 1 | Response strobe |
| rsp_unknown | output | 1 | Location cannot be resolved |
| rsp_multi | output | 1 | Multi-bit error, whole module group reported |
| rsp_module | output | 3 | Failing module, or first module of the group |
| rsp_pin | output | 10 | Failing pin number |

## Verification
The software write port and the lookup pipeline can touch the same table entry in one cycle. The bench provokes this for both the pin map and the module map. It raises a write and a request together, aimed at the very entry the request reads, with the new value chosen to differ from the old one. The response is judged against the bench's mirror of the tables taken before the write. A follow-up request must then show the new value.

// File: rtl/fault_loc_pkg.sv
package fault_loc_pkg;

   typedef enum logic [1:0] {
      KIND_PIN     = 2'd0,
      KIND_MULTI   = 2'd1,
      KIND_UNKNOWN = 2'd2
   } kind_e;

   // Reorder a single-bit syndrome into its position on one bus beat.
   function automatic int remap_code(input int code, input int data_bits, input int beat_bits);
      if (code < data_bits)
         return code + (beat_bits - data_bits);
      else if (code < beat_bits)
         return code - (beat_bits - 7);
      else if (code < beat_bits + 3)
         return code - (beat_bits - 1);
      else
         return code - (beat_bits + 3);
   endfunction

endpackage

// File: rtl/fl_map_ram.sv
module fl_map_ram #(
   parameter int DEPTH = 144,
   parameter int WIDTH = 8,
   localparam int AW = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             we,
   input  logic [AW-1:0]    waddr,
   input  logic [WIDTH-1:0] wdata,
   input  logic             re,
   input  logic [AW-1:0]    raddr,
   output logic [WIDTH-1:0] rdata
);

   logic [WIDTH-1:0] mem [DEPTH];

   // Read returns the stored value before any same-cycle write lands.
   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
      if (re) rdata <= mem[raddr];
   end

endmodule

// File: rtl/fl_index_calc.sv
module fl_index_calc
   import fault_loc_pkg::*;
#(
   parameter int SYN_W      = 10,
   parameter int LINE_OFF_W = 6,
   parameter int BEAT_BITS  = 144,
   parameter int DATA_BITS  = 128,
   parameter int BEATS      = 4,
   parameter int BEAT_BYTES = 16,
   parameter int PIN_AW     = 10,
   parameter int MOD_AW     = 8
) (
   input  logic signed [SYN_W-1:0]  syndrome,
   input  logic [LINE_OFF_W-1:0]    line_off,
   input  logic                     bank_hit,
   output kind_e                    kind,
   output logic [PIN_AW-1:0]        pin_addr,
   output logic [MOD_AW-1:0]        mod_addr,
   output logic [1:0]               field_off
);

   localparam int LINE_BITS = BEAT_BITS * BEATS;

   always_comb begin
      int code;
      int qword;
      int bus_pos;
      int line_pos;
      int rev_pos;
      code     = int'(syndrome);
      qword    = int'(line_off) / BEAT_BYTES;
      bus_pos  = remap_code(code, DATA_BITS, BEAT_BITS);
      line_pos = (BEATS - 1 - qword) * BEAT_BITS + bus_pos;
      rev_pos  = LINE_BITS - 1 - line_pos;
      kind      = KIND_PIN;
      pin_addr  = '0;
      mod_addr  = '0;
      field_off = '0;
      if (!bank_hit || code < -1 || code > BEAT_BITS) begin
         kind = KIND_UNKNOWN;
      end else if (code == -1) begin
         kind = KIND_MULTI;
      end else if (line_pos < 0) begin
         kind = KIND_UNKNOWN;
      end else begin
         pin_addr  = PIN_AW'(line_pos);
         mod_addr  = MOD_AW'(rev_pos >> 2);
         field_off = 2'(rev_pos & 3);
      end
   end

endmodule

// File: rtl/ecc_fault_locator.sv
module ecc_fault_locator
   import fault_loc_pkg::*;
#(
   parameter int SYN_W          = 10,
   parameter int PIN_W          = 10,
   parameter int BEAT_BITS      = 144,
   parameter int DATA_BITS      = 128,
   parameter int BEATS          = 4,
   parameter int BEAT_BYTES     = 16,
   parameter int MODS_PER_GROUP = 4,
   parameter int MAP_SETS       = 2,
   parameter int FIELD_BYTE_W   = 8,
   localparam int LINE_BITS  = BEAT_BITS * BEATS,
   localparam int LINE_OFF_W = $clog2(BEAT_BYTES * BEATS),
   localparam int WR_ADDR_W  = $clog2(LINE_BITS),
   localparam int MOD_W      = $clog2(2 * MODS_PER_GROUP)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    map_wr_en,
   input  logic                    map_wr_pin,
   input  logic                    map_wr_set,
   input  logic [WR_ADDR_W-1:0]    map_wr_addr,
   input  logic [PIN_W-1:0]        map_wr_data,
   input  logic                    req_valid,
   input  logic signed [SYN_W-1:0] req_syndrome,
   input  logic [LINE_OFF_W-1:0]   req_line_off,
   input  logic                    req_bank_hit,
   input  logic                    req_bank_group,
   input  logic                    req_symmetric,
   output logic                    rsp_valid,
   output logic                    rsp_unknown,
   output logic                    rsp_multi,
   output logic [MOD_W-1:0]        rsp_module,
   output logic [PIN_W-1:0]        rsp_pin
);

   localparam int MOD_DEPTH = LINE_BITS / 4;
   localparam int MOD_AW    = $clog2(MOD_DEPTH);
   localparam int PIN_AW    = $clog2(LINE_BITS);

   // Elaboration-time parameter checks
   if (MAP_SETS != 2) begin : g_bad_sets
      $error("MAP_SETS must be 2: one symmetric and one asymmetric set");
   end
   if (PIN_W < FIELD_BYTE_W) begin : g_bad_pin_w
      $error("PIN_W must cover a module-map byte");
   end
   if ((LINE_BITS % 4) != 0) begin : g_bad_line
      $error("line width must split into 2-bit fields of 8-bit bytes");
   end
   if ((1 << (MOD_W - 1)) != MODS_PER_GROUP) begin : g_bad_group
      $error("MODS_PER_GROUP must be a power of two");
   end
   if (DATA_BITS >= BEAT_BITS) begin : g_bad_beat
      $error("beat must carry check bits beyond DATA_BITS");
   end

   // Stage 0: index computation
   kind_e             kind0;
   logic [PIN_AW-1:0] pin_addr0;
   logic [MOD_AW-1:0] mod_addr0;
   logic [1:0]        off0;
   logic              set0;

   fl_index_calc #(
      .SYN_W(SYN_W), .LINE_OFF_W(LINE_OFF_W), .BEAT_BITS(BEAT_BITS),
      .DATA_BITS(DATA_BITS), .BEATS(BEATS), .BEAT_BYTES(BEAT_BYTES),
      .PIN_AW(PIN_AW), .MOD_AW(MOD_AW)
   ) u_index (
      .syndrome  (req_syndrome),
      .line_off  (req_line_off),
      .bank_hit  (req_bank_hit),
      .kind      (kind0),
      .pin_addr  (pin_addr0),
      .mod_addr  (mod_addr0),
      .field_off (off0)
   );

   assign set0 = ~req_symmetric;

   // Map sets
   logic [FIELD_BYTE_W-1:0] mod_rd [MAP_SETS];
   logic [PIN_W-1:0]        pin_rd [MAP_SETS];

   for (genvar s = 0; s < MAP_SETS; s++) begin : g_set
      logic set_wr;
      logic mod_we;
      logic pin_we;
      logic rd_en;
      assign set_wr = map_wr_en && (map_wr_set == 1'(s));
      assign mod_we = set_wr && !map_wr_pin && (map_wr_addr < WR_ADDR_W'(MOD_DEPTH));
      assign pin_we = set_wr && map_wr_pin;
      assign rd_en  = req_valid && (kind0 == KIND_PIN) && (set0 == 1'(s));

      fl_map_ram #(.DEPTH(MOD_DEPTH), .WIDTH(FIELD_BYTE_W)) u_mod_map (
         .clk   (clk),
         .we    (mod_we),
         .waddr (map_wr_addr[MOD_AW-1:0]),
         .wdata (map_wr_data[FIELD_BYTE_W-1:0]),
         .re    (rd_en),
         .raddr (mod_addr0),
         .rdata (mod_rd[s])
      );

      fl_map_ram #(.DEPTH(LINE_BITS), .WIDTH(PIN_W)) u_pin_map (
         .clk   (clk),
         .we    (pin_we),
         .waddr (map_wr_addr[PIN_AW-1:0]),
         .wdata (map_wr_data),
         .re    (rd_en),
         .raddr (pin_addr0),
         .rdata (pin_rd[s])
      );
   end

   // Stage 1: side information aligned with the table read
   logic       v1;
   kind_e      kind1;
   logic       grp1;
   logic [1:0] off1;
   logic       set1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         v1    <= 1'b0;
         kind1 <= KIND_UNKNOWN;
         grp1  <= 1'b0;
         off1  <= '0;
         set1  <= 1'b0;
      end else begin
         v1 <= req_valid;
         if (req_valid) begin
            kind1 <= kind0;
            grp1  <= req_bank_group;
            off1  <= off0;
            set1  <= set0;
         end
      end
   end

   // Stage 2: field extraction and response register
   logic [FIELD_BYTE_W-1:0] mod_byte;
   logic                    sel1;

   assign mod_byte = mod_rd[set1];
   assign sel1     = mod_byte[{~off1, 1'b0}];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid   <= 1'b0;
         rsp_unknown <= 1'b0;
         rsp_multi   <= 1'b0;
         rsp_module  <= '0;
         rsp_pin     <= '0;
      end else begin
         rsp_valid   <= v1;
         rsp_unknown <= 1'b0;
         rsp_multi   <= 1'b0;
         rsp_module  <= '0;
         rsp_pin     <= '0;
         if (v1) begin
            case (kind1)
               KIND_PIN: begin
                  rsp_module <= {grp1, {(MOD_W-1){1'b0}}} | MOD_W'(sel1);
                  rsp_pin    <= pin_rd[set1];
               end
               KIND_MULTI: begin
                  rsp_multi  <= 1'b1;
                  rsp_module <= {grp1, {(MOD_W-1){1'b0}}};
               end
               default: rsp_unknown <= 1'b1;
            endcase
         end
      end
   end

endmodule

// File: rtl/fl_checker.sv
module fl_checker #(
   parameter int SYN_W     = 10,
   parameter int PIN_W     = 10,
   parameter int MOD_W     = 3,
   parameter int BEAT_BITS = 144
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    req_valid,
   input logic signed [SYN_W-1:0] req_syndrome,
   input logic                    req_bank_hit,
   input logic                    rsp_valid,
   input logic                    rsp_unknown,
   input logic                    rsp_multi,
   input logic [MOD_W-1:0]        rsp_module,
   input logic [PIN_W-1:0]        rsp_pin
);

   logic req_bad, req_multi;
   logic q_v1, q_v2, q_bad1, q_bad2, q_mul1, q_mul2;

   assign req_bad   = req_valid && (!req_bank_hit || int'(req_syndrome) < -1 ||
                                    int'(req_syndrome) > BEAT_BITS);
   assign req_multi = req_valid && req_bank_hit && (int'(req_syndrome) == -1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q_v1 <= 1'b0; q_v2 <= 1'b0;
         q_bad1 <= 1'b0; q_bad2 <= 1'b0;
         q_mul1 <= 1'b0; q_mul2 <= 1'b0;
      end else begin
         q_v1 <= req_valid;  q_v2 <= q_v1;
         q_bad1 <= req_bad;  q_bad2 <= q_bad1;
         q_mul1 <= req_multi; q_mul2 <= q_mul1;
      end
   end

   p_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid == q_v2);

   p_bad_unknown_r2: assert property (@(posedge clk) disable iff (!rst_n)
      q_bad2 |-> rsp_unknown && !rsp_multi && rsp_pin == '0);

   p_flags_exclusive_r2: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> !(rsp_unknown && rsp_multi));

   p_multi_group_r3: assert property (@(posedge clk) disable iff (!rst_n)
      q_mul2 |-> rsp_multi && rsp_module[MOD_W-2:0] == '0 && rsp_pin == '0);

   p_selector_one_bit_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_unknown && !rsp_multi) |-> rsp_module[MOD_W-2:1] == '0);

   p_idle_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !rsp_valid |-> !rsp_unknown && !rsp_multi && rsp_module == '0 && rsp_pin == '0);

endmodule

bind ecc_fault_locator fl_checker #(
   .SYN_W(SYN_W), .PIN_W(PIN_W), .MOD_W(MOD_W), .BEAT_BITS(BEAT_BITS)
) u_fl_checker (
   .clk          (clk),
   .rst_n        (rst_n),
   .req_valid    (req_valid),
   .req_syndrome (req_syndrome),
   .req_bank_hit (req_bank_hit),
   .rsp_valid    (rsp_valid),
   .rsp_unknown  (rsp_unknown),
   .rsp_multi    (rsp_multi),
   .rsp_module   (rsp_module),
   .rsp_pin      (rsp_pin)
);

// File: tb/ecc_fault_locator_bench.sv
module ecc_fault_locator_bench;

   localparam int CLK_PERIOD = 10;

   typedef struct packed {
      logic [9:0] syn;
      logic [5:0] off;
      logic       hit;
      logic       grp;
      logic       sym;
   } vec_t;

   localparam int NV = 19;
   localparam vec_t VECS [NV] = '{
      '{10'd0,   6'd0,  1'b1, 1'b0, 1'b1},
      '{10'd127, 6'd16, 1'b1, 1'b1, 1'b1},
      '{10'd128, 6'd0,  1'b1, 1'b0, 1'b0},
      '{10'd135, 6'd32, 1'b1, 1'b1, 1'b0},
      '{10'd143, 6'd48, 1'b1, 1'b0, 1'b1},
      '{10'd144, 6'd48, 1'b1, 1'b1, 1'b0},
      '{10'd144, 6'd0,  1'b1, 1'b0, 1'b1},
      '{10'd64,  6'd40, 1'b1, 1'b1, 1'b0},
      '{10'd10,  6'd63, 1'b1, 1'b0, 1'b0},
      '{10'd137, 6'd48, 1'b1, 1'b1, 1'b1},
      '{10'h3FF, 6'd0,  1'b1, 1'b1, 1'b1},
      '{10'h3FF, 6'd20, 1'b1, 1'b0, 1'b0},
      '{10'd145, 6'd0,  1'b1, 1'b0, 1'b1},
      '{10'h3FE, 6'd0,  1'b1, 1'b0, 1'b1},
      '{10'd50,  6'd0,  1'b0, 1'b0, 1'b1},
      '{10'h3FF, 6'd0,  1'b0, 1'b1, 1'b1},
      '{10'd128, 6'd48, 1'b1, 1'b0, 1'b1},
      '{10'd136, 6'd48, 1'b1, 1'b1, 1'b0},
      '{10'd300, 6'd16, 1'b1, 1'b0, 1'b1}
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       map_wr_en = 1'b0, map_wr_pin = 1'b0, map_wr_set = 1'b0;
   logic [9:0] map_wr_addr = '0, map_wr_data = '0;
   logic       req_valid = 1'b0;
   logic signed [9:0] req_syndrome = '0;
   logic [5:0] req_line_off = '0;
   logic       req_bank_hit = 1'b0, req_bank_group = 1'b0, req_symmetric = 1'b0;
   logic       rsp_valid, rsp_unknown, rsp_multi;
   logic [2:0] rsp_module;
   logic [9:0] rsp_pin;

   int checks = 0;
   int fails  = 0;

   logic [9:0] pin_mir [2][576];
   logic [7:0] mod_mir [2][144];

   always #(CLK_PERIOD/2) clk = ~clk;

   ecc_fault_locator u_ecc_fault_locator (
      .clk(clk), .rst_n(rst_n),
      .map_wr_en(map_wr_en), .map_wr_pin(map_wr_pin), .map_wr_set(map_wr_set),
      .map_wr_addr(map_wr_addr), .map_wr_data(map_wr_data),
      .req_valid(req_valid), .req_syndrome(req_syndrome), .req_line_off(req_line_off),
      .req_bank_hit(req_bank_hit), .req_bank_group(req_bank_group),
      .req_symmetric(req_symmetric),
      .rsp_valid(rsp_valid), .rsp_unknown(rsp_unknown), .rsp_multi(rsp_multi),
      .rsp_module(rsp_module), .rsp_pin(rsp_pin)
   );

   // Reference model written from the requirements (R2..R7)
   task automatic model(input vec_t v, output logic unk, output logic mul,
                        output logic [2:0] md, output logic [9:0] pn, output string tag);
      int c, b, q, p, r, set;
      logic [7:0] byt;
      c = int'($signed(v.syn));
      unk = 1'b0; mul = 1'b0; md = '0; pn = '0; tag = "R5/R6";
      if (!v.hit || c < -1 || c > 144) begin
         unk = 1'b1; tag = "R2";
      end else if (c == -1) begin
         mul = 1'b1; md = v.grp ? 3'd4 : 3'd0; tag = "R3";
      end else begin
         if (c < 128)      b = c + 16;
         else if (c < 144) b = c - 137;
         else              b = 1;
         q = int'(v.off) / 16;
         p = (3 - q) * 144 + b;
         if (p < 0) begin
            unk = 1'b1; tag = "R5";
         end else begin
            set = v.sym ? 0 : 1;
            r = 575 - p;
            byt = mod_mir[set][r / 4];
            md = 3'((v.grp ? 4 : 0) + int'(byt[6 - 2 * (r % 4)]));
            pn = pin_mir[set][p];
            tag = "R4/R5/R6/R7";
         end
      end
   endtask

   task automatic drive_req(input vec_t v);
      req_valid      = 1'b1;
      req_syndrome   = v.syn;
      req_line_off   = v.off;
      req_bank_hit   = v.hit;
      req_bank_group = v.grp;
      req_symmetric  = v.sym;
   endtask

   task automatic compare(input vec_t v, input logic unk, input logic mul,
                          input logic [2:0] md, input logic [9:0] pn, input string tag);
      checks++;
      if (rsp_valid !== 1'b1 || rsp_unknown !== unk || rsp_multi !== mul ||
          rsp_module !== md || rsp_pin !== pn) begin
         fails++;
         $display("FAIL %s syn=%0d off=%0d: actual v=%b unk=%b multi=%b mod=%0d pin=%0d expected v=1 unk=%b multi=%b mod=%0d pin=%0d",
                  tag, $signed(v.syn), v.off, rsp_valid, rsp_unknown, rsp_multi, rsp_module,
                  rsp_pin, unk, mul, md, pn);
      end
   endtask

   task automatic check_bit(input string tag, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %b expected %b", tag, act, exp);
      end
   endtask

   task automatic run_vec(input vec_t v);
      logic unk, mul;
      logic [2:0] md;
      logic [9:0] pn;
      string tag;
      model(v, unk, mul, md, pn, tag);
      @(negedge clk); drive_req(v);
      @(negedge clk); req_valid = 1'b0;
      check_bit("R1 no early response", rsp_valid, 1'b0);
      @(negedge clk); compare(v, unk, mul, md, pn, tag);
   endtask

   task automatic write_map(input logic is_pin, input logic set, input int addr, input logic [9:0] data);
      @(negedge clk);
      map_wr_en = 1'b1; map_wr_pin = is_pin; map_wr_set = set;
      map_wr_addr = 10'(addr); map_wr_data = data;
      @(negedge clk);
      map_wr_en = 1'b0;
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      fails++;
      $display("FAIL R1 watchdog: actual run still active expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      // R9: reset state
      repeat (3) @(negedge clk);
      check_bit("R9 reset rsp_valid", rsp_valid, 1'b0);
      check_bit("R9 reset rsp_unknown", rsp_unknown, 1'b0);
      check_bit("R9 reset rsp_multi", rsp_multi, 1'b0);
      check_bit("R9 reset module zero", rsp_module == 3'd0, 1'b1);
      check_bit("R9 reset pin zero", rsp_pin == 10'd0, 1'b1);
      rst_n = 1'b1;

      // R7: load both table sets
      for (int s = 0; s < 2; s++) begin
         for (int i = 0; i < 576; i++) begin
            pin_mir[s][i] = 10'((i * 13 + s * 257 + 5) % 1024);
            write_map(1'b1, 1'(s), i, pin_mir[s][i]);
         end
         for (int i = 0; i < 144; i++) begin
            mod_mir[s][i] = 8'((i * 53 + s * 29 + 17) % 256);
            write_map(1'b0, 1'(s), i, {2'b00, mod_mir[s][i]});
         end
      end

      // Vector table walk: R2..R7
      for (int k = 0; k < NV; k++) begin
         run_vec(VECS[k]);
      end

      // R1: back-to-back requests
      begin
         logic u0, m0, u1, m1, u2, m2;
         logic [2:0] d0, d1, d2;
         logic [9:0] p0, p1, p2;
         string t0, t1, t2;
         model(VECS[1], u0, m0, d0, p0, t0);
         model(VECS[10], u1, m1, d1, p1, t1);
         model(VECS[7], u2, m2, d2, p2, t2);
         @(negedge clk); drive_req(VECS[1]);
         @(negedge clk); drive_req(VECS[10]);
         @(negedge clk); compare(VECS[1], u0, m0, d0, p0, "R1 burst 0");
         drive_req(VECS[7]);
         @(negedge clk); compare(VECS[10], u1, m1, d1, p1, "R1 burst 1");
         req_valid = 1'b0;
         @(negedge clk); compare(VECS[7], u2, m2, d2, p2, "R1 burst 2");
         @(negedge clk); check_bit("R1 single response pulse", rsp_valid, 1'b0);
         check_bit("R9 idle outputs zero", (rsp_unknown | rsp_multi | (|rsp_module) | (|rsp_pin)), 1'b0);
      end

      // R8: same-cycle write to pin map entry 448 of set 0 (syndrome 0, offset 0)
      begin
         logic u, m;
         logic [2:0] d;
         logic [9:0] p;
         string t;
         vec_t v;
         v = VECS[0];
         model(v, u, m, d, p, t);
         @(negedge clk);
         drive_req(v);
         map_wr_en = 1'b1; map_wr_pin = 1'b1; map_wr_set = 1'b0;
         map_wr_addr = 10'd448; map_wr_data = ~pin_mir[0][448];
         @(negedge clk); req_valid = 1'b0; map_wr_en = 1'b0;
         @(negedge clk); compare(v, u, m, d, p, "R8 pin old value");
         pin_mir[0][448] = ~pin_mir[0][448];
         model(v, u, m, d, p, t);
         run_vec(v);
         // module map byte 31 holds the field for reversed position 127
         model(v, u, m, d, p, t);
         @(negedge clk);
         drive_req(v);
         map_wr_en = 1'b1; map_wr_pin = 1'b0; map_wr_set = 1'b0;
         map_wr_addr = 10'd31; map_wr_data = {2'b00, mod_mir[0][31] ^ 8'h01};
         @(negedge clk); req_valid = 1'b0; map_wr_en = 1'b0;
         @(negedge clk); compare(v, u, m, d, p, "R8 module old value");
         mod_mir[0][31] = mod_mir[0][31] ^ 8'h01;
         model(v, u, m, d, p, t);
         run_vec(v);
      end

      // R7: same request against the other set differs only through table contents
      run_vec('{10'd0, 6'd0, 1'b1, 1'b0, 1'b0});

      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

endmodule